// File: doc/BRIEF.md
# Dual-Byte Bidirectional Transceiver Control

This block holds the logic-level control for two independent bytes of bus transceiver. Each byte is nine lanes wide and has an active-low enable pin and a direction pin. For each byte it produces an active-high drive enable for the A side and one for the B side, together with the nine-bit value each side would drive. Data is never inverted. When direction is high, the A-side inputs pass to the B-side outputs. When direction is low, the B-side inputs pass to the A-side outputs.

Each byte also has a guard flag. A synchronous power-on reset sets it. While the guard is set, that byte's outputs stay off, even if its enable pin is held low. The guard clears only when the enable pin is sampled high on one clock and low on the next clock. An asserted power-on reset sets the guard again.

A test-override input hands both enables and both data values of every byte to externally supplied test values. The pad logic outside the block uses the enables to switch the tristate drivers.

Top module: `dual_xcvr_ctrl`

## Requirements
- R1: With the guard clear, enable pin low and direction high, the byte's B enable is 1, its A enable is 0, and its B output equals its A input.
- R2: With the guard clear, enable pin low and direction low, the byte's A enable is 1, its B enable is 0, and its A output equals its B input.
- R3: With test override inactive and a byte's enable pin high, both of that byte's enables are 0 for either direction value.
- R4: After power-on reset is released, a byte whose enable pin stays low keeps both enables at 0.
- R5: An enable pin sampled high on one rising edge and low on the next clears that byte's guard at the second edge. From then on the byte's outputs are on while the pin stays low.
- R6: A power-on reset sampled at a rising edge sets every guard at that edge and turns every enable off. When reset and a falling enable edge fall on the same clock edge, reset wins and the guard stays set.
- R7: Each byte's guard, enables and data depend only on that byte's own pins. Byte 0 occupies bits 8:0 of each data vector and bit 0 of each per-byte vector.
- R8: While test override is 1, the A and B enables and the A and B output values equal the test-supplied values for every byte, whatever the guard, enable and direction are.
- R9: With test override inactive, a byte's A enable and B enable are never 1 together.
- R10: Guards keep tracking enable-pin edges while test override is active, so an edge seen during override takes effect once override is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| por | input | 1 | Synchronous power-on reset, active high |
| en_n | input | NB | Per-byte enable pin, active low |
| dir | input | NB | Per-byte direction: 1 means A to B, 0 means B to A |
| a_in | input | NB*W | Values seen on the A-side lanes |
| b_in | input | NB*W | Values seen on the B-side lanes |
| tst_ovr | input | 1 | Test override select |
| tst_a_oe | input | NB | Test-supplied A enables |
| tst_b_oe | input | NB | Test-supplied B enables |
| tst_a_val | input | NB*W | Test-supplied A output values |
| tst_b_val | input | NB*W | Test-supplied B output values |
| a_oe | output | NB | A-side drive enable per byte, active high |
| b_oe | output | NB | B-side drive enable per byte, active high |
| a_out | output | NB*W | Values to drive onto the A side |
| b_out | output | NB*W | Values to drive onto the B side |

## Verification
Two events can land on the same clock edge: a falling edge on an enable pin, which clears a guard, and a power-on reset, which sets it. The bench provokes this by holding the pin high and then, in a single cycle, asserting reset and pulling the pin low. It expects the guard to stay set, so the outputs remain off afterwards even though the pin stays low. The bench also lets an enable edge arrive while test override holds the outputs, then releases override. It judges this against its own per-cycle model, which expects the functional enables to appear at once.

// File: rtl/dual_xcvr_ctrl.sv
module dual_xcvr_ctrl #(
  parameter int W  = 9,
  parameter int NB = 2
) (
  input  logic            clk,
  input  logic            por,
  input  logic [NB-1:0]   en_n,
  input  logic [NB-1:0]   dir,
  input  logic [NB*W-1:0] a_in,
  input  logic [NB*W-1:0] b_in,
  input  logic            tst_ovr,
  input  logic [NB-1:0]   tst_a_oe,
  input  logic [NB-1:0]   tst_b_oe,
  input  logic [NB*W-1:0] tst_a_val,
  input  logic [NB*W-1:0] tst_b_val,
  output logic [NB-1:0]   a_oe,
  output logic [NB-1:0]   b_oe,
  output logic [NB*W-1:0] a_out,
  output logic [NB*W-1:0] b_out
);
  logic [NB-1:0] guard, en_q, fell, live;

  always_ff @(posedge clk) begin
    en_q <= en_n;
    if (por) guard <= '1;
    else     guard <= guard & ~fell;
  end

  assign fell  = en_q & ~en_n;
  assign live  = ~guard & ~en_n;
  assign a_oe  = tst_ovr ? tst_a_oe  : (live & ~dir);
  assign b_oe  = tst_ovr ? tst_b_oe  : (live & dir);
  assign a_out = tst_ovr ? tst_a_val : b_in;
  assign b_out = tst_ovr ? tst_b_val : a_in;

  for (genvar g = 0; g < NB; g++) begin : g_chk
    // R9
    excl_oe_chk: assert property (@(posedge clk) disable iff (por)
      !tst_ovr |-> !(a_oe[g] && b_oe[g]));
    // R3
    idle_hiz_chk: assert property (@(posedge clk) disable iff (por)
      (!tst_ovr && en_n[g]) |-> (!a_oe[g] && !b_oe[g]));
    // R2
    a_data_chk: assert property (@(posedge clk) disable iff (por)
      (!tst_ovr && a_oe[g]) |-> (a_out[g*W +: W] == b_in[g*W +: W]));
    // R1
    b_data_chk: assert property (@(posedge clk) disable iff (por)
      (!tst_ovr && b_oe[g]) |-> (b_out[g*W +: W] == a_in[g*W +: W]));
    // R4
    guard_after_por_chk: assert property (@(posedge clk) disable iff (por)
      ($past(por) && !tst_ovr) |-> (!a_oe[g] && !b_oe[g]));
  end
endmodule

// File: tb/dual_xcvr_ctrl_bench.sv
module dual_xcvr_ctrl_bench;
  localparam int W = 9, NB = 2;
  logic clk = 0, por = 1, tst = 0;
  logic [NB-1:0] en_n = '0, dir = '0, ta = '0, tb = '0;
  logic [NB*W-1:0] a_in = '0, b_in = '0, tva = '0, tvb = '0;
  logic [NB-1:0] a_oe, b_oe;
  logic [NB*W-1:0] a_out, b_out;
  int errors = 0, checks = 0;
  bit done = 0;
  logic [NB-1:0] mg = '1, mp = '1;

  always #10 clk = ~clk;

  dual_xcvr_ctrl #(.W(W), .NB(NB)) u_dual_xcvr_ctrl (
    .clk(clk), .por(por), .en_n(en_n), .dir(dir), .a_in(a_in), .b_in(b_in),
    .tst_ovr(tst), .tst_a_oe(ta), .tst_b_oe(tb), .tst_a_val(tva), .tst_b_val(tvb),
    .a_oe(a_oe), .b_oe(b_oe), .a_out(a_out), .b_out(b_out));

  task automatic step(input string tag);
    logic [NB-1:0] ea, eb;
    logic [NB*W-1:0] xa, xb;
    @(posedge clk);
    for (int i = 0; i < NB; i++) begin
      if (por) mg[i] = 1'b1;
      else if (mp[i] && !en_n[i]) mg[i] = 1'b0;
      mp[i] = en_n[i];
    end
    @(negedge clk);
    for (int i = 0; i < NB; i++) begin
      logic on;
      on = !mg[i] && !en_n[i];
      ea[i] = tst ? ta[i] : (on && !dir[i]);
      eb[i] = tst ? tb[i] : (on && dir[i]);
    end
    xa = tst ? tva : b_in;
    xb = tst ? tvb : a_in;
    checks++;
    if ({a_oe, b_oe, a_out, b_out} !== {ea, eb, xa, xb}) begin
      errors++;
      $display("FAIL %s: got a_oe=%b b_oe=%b a_out=%h b_out=%h, expected a_oe=%b b_oe=%b a_out=%h b_out=%h",
               tag, a_oe, b_oe, a_out, b_out, ea, eb, xa, xb);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step("R4"); step("R4");
    por = 0;
    a_in = 18'h2_B5A1; b_in = 18'h1_4C37;
    repeat (3) step("R4");
    en_n = 2'b11; step("R3");
    dir = 2'b01; en_n = 2'b10; step("R5");
    for (int k = 0; k < 4; k++) begin
      a_in = 18'(k * 18'h0_9D3 + 18'h3_0F0); step("R1");
    end
    dir = 2'b00;
    for (int k = 0; k < 4; k++) begin
      b_in = 18'(k * 18'h1_27B + 18'h0_1FF); step("R2");
    end
    en_n = 2'b11; dir = 2'b01; step("R3");
    dir = 2'b10; step("R3");
    en_n = 2'b10; step("R7");
    en_n = 2'b00; step("R7");
    dir = 2'b10; step("R9");
    dir = 2'b01; a_in = 18'h3_FFFF; b_in = 18'h0_0000; step("R9");
    dir = 2'b11; step("R9");
    tst = 1; ta = 2'b11; tb = 2'b11; tva = 18'h2_AAAA; tvb = 18'h1_5555; step("R8");
    ta = 2'b01; tb = 2'b10; tva = 18'h0_0F0F; tvb = 18'h3_F0F0; en_n = 2'b11; step("R8");
    tst = 0; en_n = 2'b00; step("R8");
    por = 1; step("R6");
    por = 0; repeat (2) step("R6");
    en_n = 2'b11; step("R6");
    por = 1; en_n = 2'b00; step("R6");
    por = 0; repeat (2) step("R6");
    en_n = 2'b11; step("R10");
    tst = 1; en_n = 2'b00; step("R10");
    tst = 0; dir = 2'b10; step("R10");
    step("R10");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule